// File: doc/BRIEF.md
# Octant-Mirrored Circle Pixel Generator

This block draws circle outlines as a stream of pixel write requests. A client supplies a centre, a radius and a colour and pulses a start input. The block then walks one octant of the circle, one row offset at a time, and for every point it computes it sends eight pixels: one in each octant. Each pixel leaves as a single transfer on a valid/ready output port aimed at a plotting engine downstream. Filling, clipping and frame buffer access are left to other blocks.

The walk never forms the square of the radius. It keeps one running error term and adds to it the differences between consecutive squares: 2y+1 when the row offset y grows by one, and 1−2x when the column offset x shrinks by one. The error term stays small and non-negative, so the arithmetic width grows by only a few bits over the coordinate width. This holds for any radius up to the largest positive coordinate. Output coordinates are two's complement and wrap modulo 2^16 when a pixel lands beyond the coordinate range.

Top module: `circle_raster`

## Requirements
- R1: After synchronous reset, `busy`, `px_valid` and `done` are all 0.
- R2: A `start` pulse while idle captures `centre_x`, `centre_y`, `radius` and `colour`. The first pixel is then (centre_x + radius, centre_y).
- R3: The walk begins at offset (x, y) = (radius, 0) with error 0. For each step, candidate = error + 2y + 1, then y increases by one. If the candidate is greater than 2x − 1, x decreases by one and 2x − 1 (old x) is subtracted from the candidate. The candidate becomes the new error.
- R4: Each point (x, y) produces eight pixels in this order of offsets: (x,y), (y,x), (−y,x), (x,−y), (−x,−y), (−y,−x), (y,−x), (−x,y). Each offset is added to the centre.
- R5: Generation ends after a step makes x less than y. The total pixel count is eight times the number of points visited.
- R6: A radius of 0 produces exactly one pixel, at the centre.
- R7: A pixel transfers only on a clock edge where `px_valid` and `px_ready` are both high. While `px_valid` is high and `px_ready` is low, `px_valid`, `px_x`, `px_y` and `px_colour` hold their values.
- R8: `done` is high for exactly one cycle: the cycle after the edge that transfers the final pixel. `busy` is low in that same cycle.
- R9: `start` is ignored while `busy` is high. A pulse with new parameters has no effect on the pixels of the circle in progress.
- R10: Pixel coordinates are the centre plus the offset, truncated to 16 bits in two's complement. A circle near the edge of the coordinate range therefore wraps.
- R11: The error term never goes negative and never overflows, for radii up to 2^15 − 1. Every pixel of a 2000-radius circle matches the exact-square reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a circle; sampled only while idle |
| centre_x | input | 16 | Centre column, signed |
| centre_y | input | 16 | Centre row, signed |
| radius | input | 15 | Radius, unsigned |
| colour | input | COLOR_W (8) | Pixel colour passed through to every pixel |
| busy | output | 1 | A circle is being generated |
| px_valid | output | 1 | A pixel request is offered |
| px_ready | input | 1 | The plotting engine accepts the offered pixel |
| px_x | output | 16 | Pixel column, signed |
| px_y | output | 16 | Pixel row, signed |
| px_colour | output | COLOR_W (8) | Pixel colour |
| done | output | 1 | One-cycle pulse after the final pixel |

## Verification
Two situations are hard to reach from the ports. The first is a back-pressure stall that lands on the eighth pixel of a point, just as the walk is about to step. The bench holds `px_ready` low on a fixed pattern with a period of three. Over many points, this pattern drops stalls on every octant index, the step pixel included. The second is an overflow of the error term, which only a large radius can reach. A 2000-radius circle and a circle wrapping at the corner of the coordinate space are compared pixel by pixel against a reference built from exact squares.

// File: rtl/circ_pkg.sv
package circ_pkg;

    localparam int CW = 16;

    typedef logic signed [CW-1:0] coord_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } point_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_t;

    // Offset for one of the eight mirror images of (a, b).
    function automatic point_t mirror(input logic [2:0] sel, input coord_t a, input coord_t b);
        point_t p;
        case (sel)
            3'd0:    begin p.x = a;  p.y = b;  end
            3'd1:    begin p.x = b;  p.y = a;  end
            3'd2:    begin p.x = -b; p.y = a;  end
            3'd3:    begin p.x = a;  p.y = -b; end
            3'd4:    begin p.x = -a; p.y = -b; end
            3'd5:    begin p.x = -b; p.y = -a; end
            3'd6:    begin p.x = b;  p.y = -a; end
            default: begin p.x = -a; p.y = b;  end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/circ_stepper.sv
module circ_stepper
    import circ_pkg::*;
#(
    parameter int RW    = CW - 1,
    parameter int ERR_W = CW + 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [RW-1:0] radius,
    output coord_t        x,
    output coord_t        y,
    output logic          last
);

    localparam logic signed [ERR_W-1:0] ONE = ERR_W'(1);

    logic signed [ERR_W-1:0] err;
    logic signed [ERR_W-1:0] xe, ye, cand, thr, err_n;
    logic                    dec;
    coord_t                  x_n, y_n;

    always_comb begin
        xe    = ERR_W'(x);
        ye    = ERR_W'(y);
        cand  = err + (ye <<< 1) + ONE;
        thr   = (xe <<< 1) - ONE;
        dec   = cand > thr;
        err_n = dec ? (cand - thr) : cand;
        x_n   = dec ? (x - coord_t'(1)) : x;
        y_n   = y + coord_t'(1);
        last  = x_n < y_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x   <= '0;
            y   <= '0;
            err <= '0;
        end else if (load) begin
            x   <= coord_t'({1'b0, radius});
            y   <= '0;
            err <= '0;
        end else if (step) begin
            x   <= x_n;
            y   <= y_n;
            err <= err_n;
        end
    end

    // R11: the running error term stays non-negative (no wrap into the sign bit)
    a_r11_err_nonneg: assert property (@(posedge clk) disable iff (rst)
        !err[ERR_W-1]);

    // R3: each step raises y by one and lowers x by at most one
    a_r3_step_shape: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (y == $past(y) + coord_t'(1)) &&
                            ((x == $past(x)) || (x == $past(x) - coord_t'(1))));

endmodule

// File: rtl/circ_octant.sv
module circ_octant #(
    parameter int N  = 8,
    parameter int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          adv,
    output logic [SW-1:0] sel,
    output logic          wrap
);

    localparam logic [SW-1:0] TOP = SW'(N - 1);

    assign wrap = (sel == TOP);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sel <= '0;
        end else if (adv) begin
            sel <= wrap ? '0 : sel + SW'(1);
        end
    end

    // R4: the octant index cycles 0..N-1 and returns to 0
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && !clear && wrap) |=> (sel == '0));

    a_r4_inc: assert property (@(posedge clk) disable iff (rst)
        (adv && !clear && !wrap) |=> (sel == $past(sel) + SW'(1)));

endmodule

// File: rtl/circ_place.sv
module circ_place
    import circ_pkg::*;
#(
    parameter int LANES = 2
) (
    input  point_t centre,
    input  point_t offs,
    output point_t pix
);

    logic [LANES-1:0][CW-1:0] c_l, o_l, p_l;

    assign c_l = {centre.x, centre.y};
    assign o_l = {offs.x, offs.y};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign p_l[g] = c_l[g] + o_l[g];
    end

    assign pix.x = coord_t'(p_l[1]);
    assign pix.y = coord_t'(p_l[0]);

endmodule

// File: rtl/circle_raster.sv
module circle_raster
    import circ_pkg::*;
#(
    parameter int COLOR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [CW-1:0]      centre_x,
    input  logic [CW-1:0]      centre_y,
    input  logic [CW-2:0]      radius,
    input  logic [COLOR_W-1:0] colour,
    output logic               busy,
    output logic               px_valid,
    input  logic               px_ready,
    output logic [CW-1:0]      px_x,
    output logic [CW-1:0]      px_y,
    output logic [COLOR_W-1:0] px_colour,
    output logic               done
);

    localparam int OCTS = 8;
    localparam int OSW  = $clog2(OCTS);

    state_t             state;
    point_t             ctr_q;
    logic [COLOR_W-1:0] col_q;
    logic               zero_q;
    logic               done_q;

    logic               hs, load, step, finish;
    logic [OSW-1:0]     sel;
    logic               wrap, last;
    coord_t             ox, oy;
    point_t             offs, pix;

    assign hs     = px_valid && px_ready;
    assign load   = (state == ST_IDLE) && start;
    assign step   = hs && wrap && !zero_q;
    assign finish = hs && (zero_q || (wrap && last));

    circ_stepper #(.RW(CW - 1), .ERR_W(CW + 3)) u_stepper (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .radius (radius),
        .x      (ox),
        .y      (oy),
        .last   (last)
    );

    circ_octant #(.N(OCTS), .SW(OSW)) u_octant (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .adv   (hs),
        .sel   (sel),
        .wrap  (wrap)
    );

    assign offs = mirror(sel, ox, oy);

    circ_place #(.LANES(2)) u_place (
        .centre (ctr_q),
        .offs   (offs),
        .pix    (pix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ctr_q  <= '0;
            col_q  <= '0;
            zero_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_EMIT;
                    ctr_q.x <= coord_t'(centre_x);
                    ctr_q.y <= coord_t'(centre_y);
                    col_q   <= colour;
                    zero_q  <= (radius == '0);
                end
                default: if (finish) begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy      = (state == ST_EMIT);
    assign px_valid  = busy;
    assign px_x      = pix.x;
    assign px_y      = pix.y;
    assign px_colour = col_q;
    assign done      = done_q;

    // R7: a stalled offer keeps its contents until taken
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (px_valid && !px_ready) |=> px_valid && $stable(px_x) && $stable(px_y) && $stable(px_colour));

    // R8: done is a single-cycle pulse that follows a transfer, with busy low
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_after_hs: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(px_valid && px_ready)));

    // R9: a start pulse while busy leaves the captured colour untouched
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (px_colour == $past(px_colour)));

    // R5: the walk only emits points with x not below y
    a_r5_order: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ox >= oy));

endmodule

// File: tb/test_circle_raster.sv
module test_circle_raster;

    localparam int CLK_PERIOD = 10;
    localparam int MAXP       = 16384;
    localparam int RUN_LIMIT  = 60000;

    logic               clk = 1'b0;
    logic               rst;
    logic               start;
    logic [15:0]        centre_x, centre_y;
    logic [14:0]        radius;
    logic [7:0]         colour;
    logic               busy, px_valid, px_ready, done;
    logic [15:0]        px_x, px_y;
    logic [7:0]         px_colour;

    int errors = 0;
    int checks = 0;

    logic signed [15:0] ex_x [0:MAXP-1];
    logic signed [15:0] ex_y [0:MAXP-1];
    int                 n_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    circle_raster #(.COLOR_W(8)) i_circle_raster (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .centre_x  (centre_x),
        .centre_y  (centre_y),
        .radius    (radius),
        .colour    (colour),
        .busy      (busy),
        .px_valid  (px_valid),
        .px_ready  (px_ready),
        .px_x      (px_x),
        .px_y      (px_y),
        .px_colour (px_colour),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic signed [15:0] cx, input logic signed [15:0] cy,
                        input int ox, input int oy);
        ex_x[n_exp] = cx + 16'(ox);
        ex_y[n_exp] = cy + 16'(oy);
        n_exp++;
    endtask

    // Reference walk from exact squares
    task automatic build_ref(input logic signed [15:0] cx, input logic signed [15:0] cy, input int r);
        longint x, y, ec;
        n_exp = 0;
        if (r == 0) begin
            push(cx, cy, 0, 0);
            return;
        end
        x = r;
        y = 0;
        forever begin
            push(cx, cy, int'(x),  int'(y));
            push(cx, cy, int'(y),  int'(x));
            push(cx, cy, -int'(y), int'(x));
            push(cx, cy, int'(x),  -int'(y));
            push(cx, cy, -int'(x), -int'(y));
            push(cx, cy, -int'(y), -int'(x));
            push(cx, cy, int'(y),  -int'(x));
            push(cx, cy, -int'(x), int'(y));
            ec = x*x + (y+1)*(y+1) - longint'(r)*r;
            y  = y + 1;
            if (ec > 2*x - 1) x = x - 1;
            if (x < y) break;
        end
    endtask

    task automatic run_circle(input logic signed [15:0] cx, input logic signed [15:0] cy,
                              input int r, input logic [7:0] col, input bit stall,
                              input bit poke, input string tag);
        int idx, cyc;
        bit held;
        logic [15:0] hx, hy;
        logic [7:0]  hc;
        build_ref(cx, cy, r);
        @(negedge clk);
        centre_x = cx; centre_y = cy; radius = 15'(r); colour = col; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx = 0; cyc = 0; held = 0; hx = '0; hy = '0; hc = '0;
        while (idx < n_exp && cyc < RUN_LIMIT) begin
            if (held) begin
                chk(px_valid && px_x == hx && px_y == hy && px_colour == hc, "R7",
                    "stalled pixel changed", longint'(px_x), longint'(hx));
                held = 0;
            end
            if (poke && cyc == 4) begin
                start = 1'b1; centre_x = cx + 16'sd100; centre_y = cy - 16'sd50;
                radius = 15'(r + 7); colour = ~col;
            end else if (poke && cyc == 5) begin
                start = 1'b0;
            end
            px_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (!px_valid) begin
                chk(1'b0, "R7", "valid dropped before last pixel", idx, n_exp);
                break;
            end
            if (px_ready) begin
                chk(px_x == ex_x[idx] && px_y == ex_y[idx] && px_colour == col,
                    (idx == 0) ? "R2" : tag, $sformatf("pixel %0d x", idx),
                    longint'($signed(px_x)), longint'(ex_x[idx]));
                if (px_y != ex_y[idx])
                    chk(1'b0, tag, $sformatf("pixel %0d y", idx),
                        longint'($signed(px_y)), longint'(ex_y[idx]));
                idx++;
            end else begin
                held = 1; hx = px_x; hy = px_y; hc = px_colour;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(idx == n_exp, "R5", "pixel count", idx, n_exp);
        chk(done && !busy, "R8", "done high and busy low after final pixel",
            {done, busy}, 2'b10);
        px_ready = 1'b0;
        @(negedge clk);
        chk(!done && !px_valid, "R8", "done pulse length", done, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; px_ready = 1'b0;
        centre_x = '0; centre_y = '0; radius = '0; colour = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !px_valid && !done, "R1", "outputs after reset",
            {busy, px_valid, done}, 0);
    endtask

    task automatic t_zero_radius;
        run_circle(16'sd40, -16'sd12, 0, 8'h5A, 1'b0, 1'b0, "R6");
        chk(n_exp == 1, "R6", "reference count for radius zero", n_exp, 1);
    endtask

    task automatic t_radius_one;
        run_circle(16'sd0, 16'sd0, 1, 8'h11, 1'b0, 1'b0, "R4");
        chk(n_exp == 16, "R4", "two points for radius one", n_exp, 16);
    endtask

    task automatic t_walk;
        run_circle(16'sd100, 16'sd200, 7, 8'h22, 1'b0, 1'b0, "R3");
        run_circle(-16'sd300, 16'sd5, 37, 8'h23, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_stall;
        run_circle(16'sd10, 16'sd20, 25, 8'h33, 1'b1, 1'b0, "R7");
    endtask

    task automatic t_busy_start;
        run_circle(-16'sd50, 16'sd60, 10, 8'h44, 1'b1, 1'b1, "R9");
    endtask

    task automatic t_wrap;
        run_circle(16'sd32700, -16'sd32700, 200, 8'h55, 1'b0, 1'b0, "R10");
    endtask

    task automatic t_large;
        run_circle(16'sd0, 16'sd0, 2000, 8'h66, 1'b0, 1'b0, "R11");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset;
        t_zero_radius;
        t_radius_one;
        t_walk;
        t_stall;
        t_busy_start;
        t_wrap;
        t_large;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule